// File: doc/BRIEF.md
# PHY Datapath Isolation and Power-Down Controller

This block decides when an Ethernet PHY's datapath may take transmit input, when the datapath is powered, and when the datapath gets a reset. Its inputs are mode bits held in the management register file: an isolate bit, a general power-down bit, an energy-sleep enable and an energy interrupt enable. It also takes a line-energy indication from the analog detector and an external active-low hardware reset. The management path is not routed through this block, so the block never gates it.

Two power-down modes exist side by side, and the general one takes priority. When the general power-down bit is released, the datapath powers up behind a fixed-length internal reset pulse. Energy sleep behaves differently. The datapath is switched off while the line is quiet. When energy returns, the datapath wakes without a reset and a strobe tells it to restore its saved operating state. The wake can also latch an interrupt, which stays set until a management read clears it. The hardware reset input counts only when it stays low for a minimum time, which is measured with a system-clock counter.

Top module: `phy_pwr_ctrl`

## Requirements
- R1: After reset, pwr_en_o=1, tx_gate_o=1 (the isolate bit resets to 0, so the datapath starts non-isolated), core_rst_o=0, irq_no=1, save_o=0, restore_o=0.
- R2: While isolate_i=1, tx_gate_o=0 in the same cycle. pwr_en_o is not affected.
- R3: From the cycle after gen_pd_i=1 is sampled, pwr_en_o=0 and tx_gate_o=0. Both stay 0 while gen_pd_i stays 1.
- R4: In the cycle after gen_pd_i returns to 0, pwr_en_o=1 and core_rst_o=1. core_rst_o stays high for exactly RST_PULSE_CYC (16) cycles.
- R5: With gen_pd_i=0, edpd_en_i=1 and energy_on_i=0, pwr_en_o=0 and tx_gate_o=0 from the next cycle on.
- R6: save_o is a one-cycle pulse in the first cycle of energy sleep. restore_o is a one-cycle pulse in the first cycle after the wake. An energy wake produces no core_rst_o pulse.
- R7: While in energy sleep, energy_on_i=1 restores pwr_en_o=1 in the next cycle.
- R8: If irq_en_i=1 at an energy wake, irq_no goes low with the wake and stays low until it is cleared. If irq_en_i=0, irq_no stays 1.
- R9: irq_clr_i=1 (the management read) returns irq_no to 1 in the next cycle. If a new wake happens in the same cycle, the set wins.
- R10: With edpd_en_i=0, energy_on_i=0 never powers the datapath down.
- R11: If general power-down and the energy-sleep condition arise together, general power-down is entered and save_o stays 0. Leaving it issues the R4 reset pulse.
- R12: A hardware reset is valid only if hw_rst_ni, after synchronization, stays low for at least HW_RST_MIN_CYC (5000) cycles. On release, a valid reset raises core_rst_o for 16 cycles, starting 3 cycles after the release. A shorter low produces no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low block reset |
| hw_rst_ni | input | 1 | External hardware reset request, active low, asynchronous |
| isolate_i | input | 1 | Isolate mode bit |
| gen_pd_i | input | 1 | General power-down bit |
| edpd_en_i | input | 1 | Energy-sleep enable bit |
| energy_on_i | input | 1 | Line energy present |
| irq_en_i | input | 1 | Energy interrupt enable |
| irq_clr_i | input | 1 | Interrupt clear, pulsed by a management read |
| tx_gate_o | output | 1 | 1 = transmit data/enable/error inputs are accepted |
| pwr_en_o | output | 1 | Datapath power enable |
| core_rst_o | output | 1 | Internal datapath reset pulse |
| irq_no | output | 1 | Energy interrupt request, active low |
| save_o | output | 1 | Strobe: save operating state before sleep |
| restore_o | output | 1 | Strobe: restore operating state after wake |

## Verification
The hardest case to reach is the qualified hardware reset. The synchronized reset line has to stay low for thousands of cycles, and the pulse only appears three cycles after release. The bench holds the line low past the limit, and separately holds it low for a much shorter time. It then checks every cycle around the release against a 16-cycle window. The collision of both power-down conditions in one cycle is driven on purpose, to show that general power-down wins and that no save strobe is issued.

// File: rtl/phy_pwr_pkg.sv
package phy_pwr_pkg;
  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_GPD   = 2'd1,
    ST_SLEEP = 2'd2
  } pwr_state_e;
endpackage

// File: rtl/phy_hwrst_qual.sv
module phy_hwrst_qual #(
  parameter int SYNC_STAGES    = 2,
  parameter int HW_RST_MIN_CYC = 5000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hw_rst_ni,
  output logic valid_o
);
  localparam int CW = $clog2(HW_RST_MIN_CYC + 1);
  localparam logic [CW-1:0] CMAX = CW'(HW_RST_MIN_CYC);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CW-1:0]          cnt_q;
  logic                   line_hi;

  assign line_hi = sync_q[SYNC_STAGES-1];

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q <= '1;
        else         sync_q <= hw_rst_ni;
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q <= '1;
        else         sync_q <= {sync_q[SYNC_STAGES-2:0], hw_rst_ni};
    end
  endgenerate

  // saturating low-time counter
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)          cnt_q <= '0;
    else if (line_hi)     cnt_q <= '0;
    else if (cnt_q != CMAX) cnt_q <= cnt_q + 1'b1;

  assign valid_o = line_hi && (cnt_q == CMAX);

  a_r12_sat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!line_hi && cnt_q == CMAX) |=> (cnt_q == CMAX || line_hi));
  a_r12_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_hi |=> cnt_q == '0);
endmodule

// File: rtl/phy_rst_pulse.sv
module phy_rst_pulse #(
  parameter int RST_PULSE_CYC = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic active_o
);
  localparam int PW = $clog2(RST_PULSE_CYC + 1);
  localparam logic [PW-1:0] PLEN = PW'(RST_PULSE_CYC);

  logic [PW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)          cnt_q <= '0;
    else if (start_i)     cnt_q <= PLEN;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;

  assign active_o = (cnt_q != '0);

  a_r4_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (cnt_q == PLEN && active_o));
  a_r4_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_o && !start_i) |=> cnt_q == $past(cnt_q) - 1'b1);
endmodule

// File: rtl/phy_pwr_fsm.sv
module phy_pwr_fsm
  import phy_pwr_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic gen_pd_i,
  input  logic edpd_en_i,
  input  logic energy_on_i,
  input  logic irq_en_i,
  input  logic irq_clr_i,
  output logic pwr_en_o,
  output logic gpd_exit_o,
  output logic irq_o,
  output logic save_o,
  output logic restore_o
);
  pwr_state_e state_q, state_d;
  logic save_q, restore_q, irq_q;
  logic go_sleep, wake, irq_set;

  always_comb begin
    state_d  = state_q;
    go_sleep = 1'b0;
    wake     = 1'b0;
    unique case (state_q)
      ST_RUN:
        if (gen_pd_i) state_d = ST_GPD;
        else if (edpd_en_i && !energy_on_i) begin
          state_d  = ST_SLEEP;
          go_sleep = 1'b1;
        end
      ST_GPD:
        if (!gen_pd_i) state_d = ST_RUN;
      ST_SLEEP:
        if (gen_pd_i) state_d = ST_GPD;
        else if (!edpd_en_i || energy_on_i) begin
          state_d = ST_RUN;
          wake    = 1'b1;
        end
      default: state_d = ST_RUN;
    endcase
  end

  assign irq_set    = wake && energy_on_i && irq_en_i;
  assign gpd_exit_o = (state_q == ST_GPD) && !gen_pd_i;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      state_q   <= ST_RUN;
      save_q    <= 1'b0;
      restore_q <= 1'b0;
      irq_q     <= 1'b0;
    end else begin
      state_q   <= state_d;
      save_q    <= go_sleep;
      restore_q <= wake;
      if (irq_set)        irq_q <= 1'b1;
      else if (irq_clr_i) irq_q <= 1'b0;
    end

  assign pwr_en_o  = (state_q == ST_RUN);
  assign irq_o     = irq_q;
  assign save_o    = save_q;
  assign restore_o = restore_q;

  a_r3_gpd_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gen_pd_i |=> state_q == ST_GPD);
  a_r5_sleep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!gen_pd_i && edpd_en_i && !energy_on_i && state_q != ST_GPD) |=> state_q == ST_SLEEP);
  a_r10_no_edpd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!gen_pd_i && !edpd_en_i) |=> state_q == ST_RUN);
  a_r8_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_q && !irq_clr_i) |=> irq_q);
  a_r9_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_clr_i && !(state_q == ST_SLEEP && energy_on_i)) |=> !irq_q);
  a_r6_strobes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(save_q && restore_q));
endmodule

// File: rtl/phy_pwr_ctrl.sv
module phy_pwr_ctrl #(
  parameter int RST_PULSE_CYC  = 16,
  parameter int HW_RST_MIN_CYC = 5000,
  parameter int SYNC_STAGES    = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hw_rst_ni,
  input  logic isolate_i,
  input  logic gen_pd_i,
  input  logic edpd_en_i,
  input  logic energy_on_i,
  input  logic irq_en_i,
  input  logic irq_clr_i,
  output logic tx_gate_o,
  output logic pwr_en_o,
  output logic core_rst_o,
  output logic irq_no,
  output logic save_o,
  output logic restore_o
);
  logic hw_valid, gpd_exit, irq;

  phy_hwrst_qual #(
    .SYNC_STAGES   (SYNC_STAGES),
    .HW_RST_MIN_CYC(HW_RST_MIN_CYC)
  ) u_hwrst (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .hw_rst_ni(hw_rst_ni),
    .valid_o  (hw_valid)
  );

  phy_pwr_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .gen_pd_i   (gen_pd_i),
    .edpd_en_i  (edpd_en_i),
    .energy_on_i(energy_on_i),
    .irq_en_i   (irq_en_i),
    .irq_clr_i  (irq_clr_i),
    .pwr_en_o   (pwr_en_o),
    .gpd_exit_o (gpd_exit),
    .irq_o      (irq),
    .save_o     (save_o),
    .restore_o  (restore_o)
  );

  phy_rst_pulse #(.RST_PULSE_CYC(RST_PULSE_CYC)) u_pulse (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (gpd_exit || hw_valid),
    .active_o(core_rst_o)
  );

  assign tx_gate_o = pwr_en_o && !isolate_i;
  assign irq_no    = !irq;

  a_r6_no_rst_on_wake: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (restore_o && !$past(core_rst_o) && !$past(hw_valid)) |-> !core_rst_o);
endmodule

// File: tb/phy_pwr_ctrl_tb_top.sv
module phy_pwr_ctrl_tb_top;
  typedef struct {
    bit pwr; bit tx; bit rst; bit irqn; bit sv; bit rs;
    string tag;
  } exp_t;

  logic clk = 0, rst_n = 0, hw_rst_n = 1;
  logic iso = 0, gpd = 0, edpd = 0, en = 1, ie = 0, clr = 0;
  logic tx_gate, pwr_en, core_rst, irq_n, save, restore;
  int checks = 0, fails = 0;
  bit done = 0;
  exp_t q[$];

  always #10 clk = ~clk;

  phy_pwr_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .hw_rst_ni(hw_rst_n),
    .isolate_i(iso), .gen_pd_i(gpd), .edpd_en_i(edpd), .energy_on_i(en),
    .irq_en_i(ie), .irq_clr_i(clr),
    .tx_gate_o(tx_gate), .pwr_en_o(pwr_en), .core_rst_o(core_rst),
    .irq_no(irq_n), .save_o(save), .restore_o(restore)
  );

  function automatic exp_t mk(bit p, bit t, bit r, bit i, bit s, bit rs, string tag);
    exp_t e;
    e.pwr = p; e.tx = t; e.rst = r; e.irqn = i; e.sv = s; e.rs = rs; e.tag = tag;
    return e;
  endfunction

  // monitor: compare one expected item per cycle, away from the edge
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if ({pwr_en, tx_gate, core_rst, irq_n, save, restore} !=
          {e.pwr, e.tx, e.rst, e.irqn, e.sv, e.rs}) begin
        fails++;
        $display("FAIL %s: got pwr=%b tx=%b rst=%b irqn=%b sv=%b rs=%b exp %b%b%b%b%b%b",
                 e.tag, pwr_en, tx_gate, core_rst, irq_n, save, restore,
                 e.pwr, e.tx, e.rst, e.irqn, e.sv, e.rs);
      end
    end
  end

  task automatic drive(bit i_iso, bit i_gpd, bit i_edpd, bit i_en, bit i_ie, bit i_clr, exp_t e);
    @(negedge clk);
    iso = i_iso; gpd = i_gpd; edpd = i_edpd; en = i_en; ie = i_ie; clr = i_clr;
    q.push_back(e);
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic hw_pulse(int low_cyc, bit expect_pulse, string tag);
    @(negedge clk); hw_rst_n = 0;
    wait_cyc(low_cyc);
    hw_rst_n = 1;
    q.push_back(mk(1, 1, 0, 1, 0, 0, tag));
    for (int i = 0; i < 18; i++) begin
      @(negedge clk);
      if (i == 0 || i == 17) q.push_back(mk(1, 1, 0, 1, 0, 0, tag));
      else                   q.push_back(mk(1, 1, expect_pulse, 1, 0, 0, tag));
    end
  endtask

  initial begin
    #4000000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    drive(0,0,0,1,0,0, mk(1,1,0,1,0,0,"R1 reset"));
    // R2 isolate
    drive(1,0,0,1,0,0, mk(1,0,0,1,0,0,"R2 isolate"));
    drive(0,0,0,1,0,0, mk(1,1,0,1,0,0,"R2 unisolate"));
    // R3 general power-down
    for (int i = 0; i < 3; i++) drive(0,1,0,1,0,0, mk(0,0,0,1,0,0,"R3 gpd"));
    // R4 exit with reset pulse
    for (int i = 0; i < 16; i++) drive(0,0,0,1,0,0, mk(1,1,1,1,0,0,"R4 pulse"));
    drive(0,0,0,1,0,0, mk(1,1,0,1,0,0,"R4 pulse end"));
    // R5/R6 energy sleep with save strobe
    drive(0,0,1,0,1,0, mk(0,0,0,1,1,0,"R6 save"));
    drive(0,0,1,0,1,0, mk(0,0,0,1,0,0,"R5 sleep"));
    // R7/R8 wake with interrupt, restore strobe, no reset
    drive(0,0,1,1,1,0, mk(1,1,0,0,0,1,"R7 R8 wake"));
    drive(0,0,1,1,1,0, mk(1,1,0,0,0,0,"R8 latched"));
    drive(0,0,1,1,1,0, mk(1,1,0,0,0,0,"R8 latched"));
    // R9 clear
    drive(0,0,1,1,1,1, mk(1,1,0,1,0,0,"R9 clear"));
    // R8 no interrupt when disabled
    drive(0,0,1,0,0,0, mk(0,0,0,1,1,0,"R8 sleep2"));
    drive(0,0,1,1,0,0, mk(1,1,0,1,0,1,"R8 wake no irq"));
    // R9 set wins over clear
    drive(0,0,1,0,1,0, mk(0,0,0,1,1,0,"R9 sleep3"));
    drive(0,0,1,1,1,1, mk(1,1,0,0,0,1,"R9 set wins"));
    drive(0,0,1,1,1,1, mk(1,1,0,1,0,0,"R9 clear after"));
    // R10 disabled energy sleep
    for (int i = 0; i < 3; i++) drive(0,0,0,0,0,0, mk(1,1,0,1,0,0,"R10 no sleep"));
    // R11 priority
    drive(0,1,1,0,0,0, mk(0,0,0,1,0,0,"R11 gpd wins"));
    drive(0,1,1,0,0,0, mk(0,0,0,1,0,0,"R11 gpd hold"));
    drive(0,0,1,1,0,0, mk(1,1,1,1,0,0,"R11 exit reset"));
    for (int i = 0; i < 15; i++) drive(0,0,0,1,0,0, mk(1,1,1,1,0,0,"R11 pulse"));
    drive(0,0,0,1,0,0, mk(1,1,0,1,0,0,"R11 pulse end"));
    // R12 hardware reset qualification
    hw_pulse(100, 0, "R12 short");
    hw_pulse(5100, 1, "R12 long");
    wait_cyc(3);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule